// File: doc/BRIEF.md
# Time Beacon Broadcaster with Master Failover

This block sits in every bus master that is able to keep time for the whole bus. While it holds the time-keeper role it sends a short time frame at a fixed 2.5 ms rhythm. The frame goes out on every lane at once, as a byte stream with a control-character flag. While it does not hold the role it runs a silence timer. The timer is longer for a higher node number, so that when the current time keeper falls silent the backup with the lowest number takes over first and the others hear its frames before their own timers run out.

The frame carries either the sub-second time (milliseconds, microseconds, nanoseconds) or, once after each change of the seconds value, the seconds count. The time code is taken from the local counter inputs at the clock edge that puts the control character on the lanes. A time keeper that hears a frame from a node with a lower number gives up the role. Parsing of received frames happens elsewhere: this block sees only a one-cycle "frame heard" pulse and the sender's number.

Timing is expressed in clock cycles through `CYC_PER_MS`. The broadcast period is `CYC_PER_MS*5/2` cycles and the silence limit is `3*node_id*CYC_PER_MS` cycles.

Top module: `time_beacon_failover`

## Requirements
- R1: During and right after reset, `master_on` is 1 when `node_id` is 0 and 0 for any other node number; the lanes are idle (valid low, K flags low, data zero).
- R2: Node 0 puts the control character on the lanes in the first cycle after the first clock edge with reset released.
- R3: While `master_on` stays high, consecutive control characters are exactly `CYC_PER_MS*5/2` cycles apart.
- R4: A frame is 7 consecutive valid bytes: 8'h9C with the K flag set, then the command byte {node_id[4:0], cmd[2:0]}, then the four time-code bytes most significant first, then a check byte equal to the 8-bit sum of the command byte and the four code bytes. The K flag is set on the first byte only; between frames the lanes are idle as in R1.
- R5: All `LANES` lanes carry the same byte and K flag in every cycle.
- R6: If the seconds input differs from the seconds value sent in the last seconds frame (0 after reset), the frame uses cmd 1 and the code is the 32-bit seconds value; otherwise it uses cmd 0 and the code is {4'b0, ms[9:0], us[9:0], ns[7:0]}.
- R7: The time code and seconds decision use the input values at the clock edge that puts the control character on the lanes.
- R8: A non-master with node number n that hears no frame for 3*n*`CYC_PER_MS` consecutive edges raises `master_on` at the last of them and emits a control character one cycle later.
- R9: A frame heard while not master restarts the silence timer, including at the very edge on which the timer would have expired.
- R10: A master hearing a frame whose sender number is below its own drops `master_on` at that edge; a frame from an equal or higher number leaves the role and the broadcast rhythm unchanged.
- R11: A frame already in progress when the role is dropped is completed; no new frame starts while `master_on` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| node_id | input | 5 | This node's number (static) |
| pkt_seen | input | 1 | One-cycle pulse: a time frame was heard |
| pkt_src_id | input | 5 | Sender number of the heard frame |
| loc_sec | input | 32 | Local seconds count |
| loc_ms | input | 10 | Local milliseconds (0..999) |
| loc_us | input | 10 | Local microseconds (0..999) |
| loc_ns | input | 8 | Local nanoseconds (0..255) |
| lane_data | output | LANES*8 | Byte per lane, lane i in bits [8i+7:8i] |
| lane_k | output | LANES | Control-character flag per lane |
| lane_vld | output | 1 | Frame byte present on the lanes |
| master_on | output | 1 | This node currently holds the time-keeper role |

## Verification
Two collisions matter most. A heard frame can arrive on the same edge at which the silence timer would expire, and the bench places such a pulse exactly on that edge, then checks that the node stays passive and that the next takeover comes one full timer length later. A lower-numbered frame can also be heard two bytes into the node's own frame, and the bench checks that the frame still ends cleanly with its check byte, that the next period slot stays silent, and that the timer then restarts from that edge. A behavioural queue model predicts every lane byte and the role bit on every cycle.

// File: rtl/tbf_pkg.sv
// Shared constants and helpers for the time beacon block.
// Assumes node numbers fit the 5-bit field of the command byte.
package tbf_pkg;
    localparam logic [7:0] CTRL_CHAR = 8'h9C;   // K28.4
    localparam int         FRAME_LEN = 7;
    localparam int         MAX_ID    = 31;

    typedef enum logic [2:0] {
        CMD_SYNC    = 3'd0,
        CMD_SECONDS = 3'd1
    } tcmd_e;

    // 8-bit wrapping sum over command byte and the four code bytes
    function automatic logic [7:0] frame_sum(input logic [7:0] cmd_b, input logic [31:0] code);
        frame_sum = cmd_b + code[31:24] + code[23:16] + code[15:8] + code[7:0];
    endfunction
endpackage

// File: rtl/tbf_role.sv
// Role keeper: holds the time-keeper role bit and the silence timer.
// Assumes node_id is static; pkt_seen is a one-cycle pulse per heard frame.
module tbf_role #(
    parameter int WD_UNIT = 120,
    parameter int WD_W    = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] node_id,
    input  logic       pkt_seen,
    input  logic [4:0] pkt_src_id,
    output logic       master_on
);
    logic            master_q;
    logic [WD_W-1:0] wd_q;
    logic [WD_W-1:0] wd_len;
    logic [WD_W-1:0] wd_last;
    logic            outranked;

    // silence limit grows with node number
    always_comb begin
        wd_len    = WD_W'(WD_UNIT) * WD_W'(node_id);
        wd_last   = wd_len - 1'b1;
        outranked = pkt_seen && (pkt_src_id < node_id);
    end

    // role bit and silence timer update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q <= (node_id == 5'd0);
            wd_q     <= '0;
        end else if (master_q) begin
            if (outranked) begin
                master_q <= 1'b0;
                wd_q     <= '0;
            end
        end else if (pkt_seen) begin
            wd_q <= '0;
        end else if (wd_q == wd_last) begin
            master_q <= 1'b1;
            wd_q     <= '0;
        end else begin
            wd_q <= wd_q + 1'b1;
        end
    end

    assign master_on = master_q;
endmodule

// File: rtl/tbf_pacer.sv
// Period pacer: issues a frame start every PERIOD cycles while master.
// Assumes PERIOD exceeds the frame length so starts never overlap a frame.
module tbf_pacer #(
    parameter int PERIOD = 100,
    parameter int PW     = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_on,
    input  logic frame_busy,
    output logic start
);
    logic [PW-1:0] per_q;

    // phase counter, held at zero while passive
    always_ff @(posedge clk) begin
        if (!rst_n || !master_on) begin
            per_q <= '0;
        end else if (per_q == PW'(PERIOD - 1)) begin
            per_q <= '0;
        end else begin
            per_q <= per_q + 1'b1;
        end
    end

    // start at phase zero of each period
    assign start = master_on && (per_q == '0) && !frame_busy;
endmodule

// File: rtl/tbf_framer.sv
// Frame builder: snapshots the time code on start and walks the 7 bytes.
// Assumes start is a single-cycle pulse issued only while idle.
module tbf_framer
    import tbf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [4:0]  node_id,
    input  logic [31:0] loc_sec,
    input  logic [9:0]  loc_ms,
    input  logic [9:0]  loc_us,
    input  logic [7:0]  loc_ns,
    output logic [7:0]  out_byte,
    output logic        out_k,
    output logic        out_vld,
    output logic        busy
);
    logic        busy_q;
    logic [2:0]  idx_q;
    tcmd_e       cmd_q;
    logic [31:0] code_q;
    logic [31:0] last_sec_q;
    logic [4:0]  id_q;
    logic [7:0]  cmd_byte;

    // snapshot on start, then advance one byte per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            idx_q      <= '0;
            cmd_q      <= CMD_SYNC;
            code_q     <= '0;
            last_sec_q <= '0;
            id_q       <= '0;
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            id_q   <= node_id;
            if (loc_sec != last_sec_q) begin
                cmd_q      <= CMD_SECONDS;
                code_q     <= loc_sec;
                last_sec_q <= loc_sec;
            end else begin
                cmd_q  <= CMD_SYNC;
                code_q <= {4'b0000, loc_ms, loc_us, loc_ns};
            end
        end else if (busy_q) begin
            if (idx_q == 3'(FRAME_LEN - 1)) begin
                busy_q <= 1'b0;
                idx_q  <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // byte selection for the current frame position
    always_comb begin
        cmd_byte = {id_q, cmd_q};
        out_byte = 8'h00;
        out_k    = 1'b0;
        if (busy_q) begin
            case (idx_q)
                3'd0:    begin out_byte = CTRL_CHAR; out_k = 1'b1; end
                3'd1:    out_byte = cmd_byte;
                3'd2:    out_byte = code_q[31:24];
                3'd3:    out_byte = code_q[23:16];
                3'd4:    out_byte = code_q[15:8];
                3'd5:    out_byte = code_q[7:0];
                default: out_byte = frame_sum(cmd_byte, code_q);
            endcase
        end
    end

    assign out_vld = busy_q;
    assign busy    = busy_q;
endmodule

// File: rtl/time_beacon_failover.sv
// Top: time beacon broadcaster with staggered master failover.
// Assumes CYC_PER_MS*5/2 > 7 and that node_id changes only under reset.
module time_beacon_failover #(
    parameter int LANES      = 4,
    parameter int CYC_PER_MS = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [4:0]         node_id,
    input  logic               pkt_seen,
    input  logic [4:0]         pkt_src_id,
    input  logic [31:0]        loc_sec,
    input  logic [9:0]         loc_ms,
    input  logic [9:0]         loc_us,
    input  logic [7:0]         loc_ns,
    output logic [LANES*8-1:0] lane_data,
    output logic [LANES-1:0]   lane_k,
    output logic               lane_vld,
    output logic               master_on
);
    localparam int PERIOD  = (CYC_PER_MS * 5) / 2;
    localparam int PW      = $clog2(PERIOD);
    localparam int WD_UNIT = 3 * CYC_PER_MS;
    localparam int WD_W    = $clog2(WD_UNIT * tbf_pkg::MAX_ID + 1);

    logic       start;
    logic       busy;
    logic [7:0] fr_byte;
    logic       fr_k;

    tbf_role #(.WD_UNIT(WD_UNIT), .WD_W(WD_W)) u_role (
        .clk(clk), .rst_n(rst_n), .node_id(node_id),
        .pkt_seen(pkt_seen), .pkt_src_id(pkt_src_id), .master_on(master_on)
    );

    tbf_pacer #(.PERIOD(PERIOD), .PW(PW)) u_pacer (
        .clk(clk), .rst_n(rst_n), .master_on(master_on),
        .frame_busy(busy), .start(start)
    );

    tbf_framer u_framer (
        .clk(clk), .rst_n(rst_n), .start(start), .node_id(node_id),
        .loc_sec(loc_sec), .loc_ms(loc_ms), .loc_us(loc_us), .loc_ns(loc_ns),
        .out_byte(fr_byte), .out_k(fr_k), .out_vld(lane_vld), .busy(busy)
    );

    // same byte and flag on every lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_data[g*8 +: 8] = fr_byte;
        assign lane_k[g]           = fr_k;
    end
endmodule

// File: rtl/tbf_chk.sv
// Checker for the time beacon top; attached by bind below.
// Assumes synchronous active-low reset on rst_n.
module tbf_chk #(
    parameter int LANES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [4:0]         node_id,
    input logic               pkt_seen,
    input logic [4:0]         pkt_src_id,
    input logic [LANES*8-1:0] lane_data,
    input logic [LANES-1:0]   lane_k,
    input logic               lane_vld,
    input logic               master_on
);
    logic [3:0] run_q;

    // length of the current run of valid bytes
    always_ff @(posedge clk) begin
        if (!rst_n || !lane_vld) run_q <= '0;
        else if (run_q != 4'hF)  run_q <= run_q + 1'b1;
    end

    a_r4_k_is_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        lane_k[0] |-> (lane_vld && lane_data[7:0] == 8'h9C));

    a_r4_k_once: assert property (@(posedge clk) disable iff (!rst_n)
        lane_k[0] |=> (lane_vld && !lane_k[0]));

    a_r4_seven_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lane_vld) |-> (run_q == 4'd7));

    a_r11_start_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_vld) |-> $past(master_on));

    a_r8_takeover_emits: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(master_on) |=> lane_k[0]);

    a_r10_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (master_on && pkt_seen && (pkt_src_id < node_id)) |=> !master_on);

    a_r10_keep_role: assert property (@(posedge clk) disable iff (!rst_n)
        (master_on && !(pkt_seen && (pkt_src_id < node_id))) |=> master_on);

    a_r9_heard_stays_passive: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_on && pkt_seen) |=> !master_on);
endmodule

bind time_beacon_failover tbf_chk #(.LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .node_id(node_id), .pkt_seen(pkt_seen),
    .pkt_src_id(pkt_src_id), .lane_data(lane_data), .lane_k(lane_k),
    .lane_vld(lane_vld), .master_on(master_on)
);

// File: tb/time_beacon_failover_test.sv
module time_beacon_failover_test;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 3;
    localparam int CPM        = 8;
    localparam int PER        = (CPM * 5) / 2;
    localparam int WDU        = 3 * CPM;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [4:0]         node_id = 5'd0;
    logic               pkt_seen = 1'b0;
    logic [4:0]         pkt_src_id = 5'd0;
    logic [31:0]        loc_sec = '0;
    logic [9:0]         loc_ms = '0;
    logic [9:0]         loc_us = '0;
    logic [7:0]         loc_ns = '0;
    logic [LANES*8-1:0] lane_data;
    logic [LANES-1:0]   lane_k;
    logic               lane_vld;
    logic               master_on;

    time_beacon_failover #(.LANES(LANES), .CYC_PER_MS(CPM)) uut (
        .clk(clk), .rst_n(rst_n), .node_id(node_id), .pkt_seen(pkt_seen),
        .pkt_src_id(pkt_src_id), .loc_sec(loc_sec), .loc_ms(loc_ms),
        .loc_us(loc_us), .loc_ns(loc_ns), .lane_data(lane_data),
        .lane_k(lane_k), .lane_vld(lane_vld), .master_on(master_on)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    total = 0;
    int    bad = 0;
    int    ecount = 0;
    bit    done = 0;
    bit    model_live = 0;
    string cur_req = "R1";

    // time base as a function of the edge number that samples it
    function automatic logic [31:0] f_sec(int e); return 32'(e / 50); endfunction
    function automatic logic [9:0]  f_ms(int e);  return 10'((e * 3) % 1000); endfunction
    function automatic logic [9:0]  f_us(int e);  return 10'((e * 37) % 1000); endfunction
    function automatic logic [7:0]  f_ns(int e);  return 8'((e * 11) % 256); endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) ecount <= 0;
        else        ecount <= ecount + 1;
    end

    always @(negedge clk) begin
        loc_sec <= f_sec(ecount + 1);
        loc_ms  <= f_ms(ecount + 1);
        loc_us  <= f_us(ecount + 1);
        loc_ns  <= f_ns(ecount + 1);
    end

    // behavioural reference: queue of expected {k, byte} entries
    logic [8:0]  q[$];
    bit          m_master = 0;
    int          m_wd = 0;
    int          m_per = 0;
    logic [31:0] m_last = '0;

    task automatic push_frame();
        logic [7:0]  cb;
        logic [31:0] code;
        int          s;
        if (loc_sec != m_last) begin
            cb = {node_id, 3'd1}; code = loc_sec; m_last = loc_sec;
        end else begin
            cb = {node_id, 3'd0}; code = {4'b0000, loc_ms, loc_us, loc_ns};
        end
        s = (int'(cb) + int'(code[31:24]) + int'(code[23:16]) + int'(code[15:8]) + int'(code[7:0])) % 256;
        q.push_back({1'b1, 8'h9C});
        q.push_back({1'b0, cb});
        q.push_back({1'b0, code[31:24]});
        q.push_back({1'b0, code[23:16]});
        q.push_back({1'b0, code[15:8]});
        q.push_back({1'b0, code[7:0]});
        q.push_back({1'b0, 8'(s)});
    endtask

    always @(posedge clk) begin
        bit old;
        model_live = 1;
        if (!rst_n) begin
            m_master = (node_id == 0); m_wd = 0; m_per = 0; m_last = '0; q.delete();
        end else begin
            old = m_master;
            if (q.size() > 0) void'(q.pop_front());
            if (old && m_per == 0 && q.size() == 0) push_frame();
            if (old) m_per = (m_per == PER - 1) ? 0 : m_per + 1;
            else     m_per = 0;
            if (old) begin
                if (pkt_seen && pkt_src_id < node_id) begin m_master = 0; m_wd = 0; end
            end else if (pkt_seen) m_wd = 0;
            else if (m_wd == WDU * int'(node_id) - 1) begin m_master = 1; m_wd = 0; end
            else m_wd++;
        end
    end

    // per-cycle comparison against the model (R4, R5, R11 on every byte)
    always @(negedge clk) begin
        logic [8:0] e;
        if (model_live && !done) begin
            e = (q.size() > 0) ? q[0] : 9'h000;
            chk(64'(master_on), 64'(m_master), {cur_req, " model role"});
            chk(64'(lane_vld), 64'(q.size() > 0), {cur_req, " model R11 valid"});
            for (int i = 0; i < LANES; i++) begin
                chk(64'(lane_data[i*8 +: 8]), 64'(e[7:0]), {cur_req, " model R5 lane byte"});
                chk(64'(lane_k[i]), 64'(e[8]), {cur_req, " model R4 k flag"});
            end
        end
    end

    task automatic to_edge(input int n);
        while (ecount < n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [4:0] id);
        rst_n = 1'b0; node_id = id; pkt_seen = 1'b0; pkt_src_id = '0;
        repeat (3) @(negedge clk);
        cur_req = "R1";
        chk(64'(master_on), 64'(id == 0), "R1 role in reset");
        chk(64'(lane_vld), 64'd0, "R1 idle valid");
        chk(64'(lane_k), 64'd0, "R1 idle k");
        rst_n = 1'b1;
    endtask

    // pulse sampled at edge n
    task automatic pulse_at(input int n, input logic [4:0] src);
        to_edge(n - 1);
        pkt_seen = 1'b1; pkt_src_id = src;
        @(negedge clk);
        pkt_seen = 1'b0;
    endtask

    task automatic check_frame(input int e, input logic [2:0] cmd, input logic [31:0] code,
                               input logic [4:0] id, input string req);
        logic [7:0] b[7];
        int s;
        b[0] = 8'h9C; b[1] = {id, cmd};
        b[2] = code[31:24]; b[3] = code[23:16]; b[4] = code[15:8]; b[5] = code[7:0];
        s = (int'(b[1]) + int'(b[2]) + int'(b[3]) + int'(b[4]) + int'(b[5])) % 256;
        b[6] = 8'(s);
        to_edge(e);
        for (int i = 0; i < 7; i++) begin
            chk(64'(lane_data[7:0]), 64'(b[i]), req);
            chk(64'(lane_k[0]), 64'(i == 0), req);
            chk(64'(lane_vld), 64'd1, req);
            @(negedge clk);
        end
        chk(64'(lane_vld), 64'd0, {req, " R4 idle after frame"});
    endtask

    initial begin
        // node 0: start-up master
        do_reset(5'd0);
        cur_req = "R2";
        to_edge(1);
        chk(64'(lane_k), 64'h7, "R2 first control char");
        chk(64'(lane_data), 64'h9C9C9C, "R2 R5 control on all lanes");
        cur_req = "R3";
        to_edge(20);
        chk(64'(lane_k[0]), 64'd0, "R3 no control before period");
        to_edge(21);
        chk(64'(lane_k[0]), 64'd1, "R3 control after one period");
        to_edge(41);
        chk(64'(lane_k[0]), 64'd1, "R3 control after two periods");
        cur_req = "R6";
        check_frame(61, 3'd1, f_sec(61), 5'd0, "R6 seconds frame");
        cur_req = "R7";
        check_frame(81, 3'd0, {4'b0000, f_ms(81), f_us(81), f_ns(81)}, 5'd0, "R7 sync frame snapshot");
        cur_req = "R10";
        pulse_at(90, 5'd5);
        chk(64'(master_on), 64'd1, "R10 higher sender ignored");
        to_edge(101);
        chk(64'(lane_k[0]), 64'd1, "R10 rhythm unchanged");

        // node 2: coincidence of heard frame and expiry, takeover, step-down
        do_reset(5'd2);
        cur_req = "R9";
        pulse_at(21, 5'd7);
        to_edge(68);
        chk(64'(master_on), 64'd0, "R9 restarted timer");
        pulse_at(69, 5'd0);
        chk(64'(master_on), 64'd0, "R9 heard frame wins at expiry");
        cur_req = "R8";
        to_edge(116);
        chk(64'(master_on), 64'd0, "R8 before limit");
        to_edge(117);
        chk(64'(master_on), 64'd1, "R8 takeover at limit");
        to_edge(118);
        chk(64'(lane_k[0]), 64'd1, "R8 control after takeover");
        cur_req = "R10";
        pulse_at(120, 5'd1);
        chk(64'(master_on), 64'd0, "R10 lower sender steps down");
        cur_req = "R11";
        to_edge(124);
        chk(64'(lane_vld), 64'd1, "R11 frame completes");
        to_edge(125);
        chk(64'(lane_vld), 64'd0, "R11 frame ended");
        to_edge(138);
        chk(64'(lane_vld), 64'd0, "R11 no frame while passive");
        cur_req = "R8";
        to_edge(168);
        chk(64'(master_on), 64'd1, "R8 retake after step-down");
        to_edge(169);
        chk(64'(lane_k[0]), 64'd1, "R8 control after retake");
        cur_req = "R10";
        pulse_at(175, 5'd2);
        chk(64'(master_on), 64'd1, "R10 equal sender ignored");

        // node 31: longest limit
        do_reset(5'd31);
        cur_req = "R8";
        to_edge(743);
        chk(64'(master_on), 64'd0, "R8 node 31 before limit");
        to_edge(744);
        chk(64'(master_on), 64'd1, "R8 node 31 takeover");
        to_edge(745);
        chk(64'(lane_k[0]), 64'd1, "R8 node 31 control");
        to_edge(760);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog %s run did not finish", cur_req);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule